// File: doc/BRIEF.md
# Scan Line Doubler

This block takes a standard-rate video line stream (luma plus two colour-difference components) and produces a stream with twice the line rate, suitable for a progressive monitor. It captures each incoming line into on-chip dual-port line memory as the samples arrive. It then plays that line back twice, each time at the full clock rate, and produces a fresh horizontal sync pulse for each playback. A 15.6 kHz input line rate therefore becomes a 31.3 kHz output line rate. The field rate does not change, and the vertical sync passes straight through.

The block uses one clock. Input samples are qualified by a strobe that normally fires on every other clock, which makes the clock twice the input pixel rate. Each line memory has two banks used in ping-pong fashion. The line that ends at an input hsync is played out from one bank while the next line is written into the other. The two colour-difference components are taken from even-numbered luma positions only, and are kept in memories of half depth. If an input line ends early, the unwritten tail of the line plays back as black.

Top module: `scanDoubler`

## Requirements
- R1: During and after reset, until the first `inHsync`, `outValid`, `outHsync` and `outVsync` are 0, `outLuma` is 0, and `outCb` and `outCr` are at midscale (2^(PIX_W-1)).
- R2: A line starts at an `inHsync`. The sample whose `inValid` coincides with `inHsync` is stored at position 0, and each later valid sample is stored at the next position. Samples that arrive before the first `inHsync`, and samples past position LINE_LEN-1, are discarded.
- R3: The edge that samples `inHsync` high (edge T) starts playback of the line that this hsync closes. Readout cycle m of the first playback appears on the outputs after edge T+1+m. A second playback follows directly, and each playback lasts HALF_PERIOD clocks.
- R4: `outHsync` is high for readout cycles 0 to syncWidth-1 of each playback. A `syncWidth` of 0 gives no pulse, and a value of HALF_PERIOD or more keeps it high for the whole playback.
- R5: `outValid` is high for readout cycles ACT_START to ACT_START+LINE_LEN-1 of each playback. At readout cycle ACT_START+k, `outLuma` carries stored sample k.
- R6: `inCb` and `inCr` are stored only for even positions. At readout cycle ACT_START+k, `outCb` and `outCr` carry the chroma values stored at position k with its lowest bit cleared.
- R7: A position at or past the number of samples the line captured plays back as black (luma 0, chroma midscale) while `outValid` stays high. The data outputs are also black whenever `outValid` is 0.
- R8: After both playbacks, `outValid` and `outHsync` stay 0 until the next `inHsync`.
- R9: An `inHsync` that arrives during a playback abandons the rest of it and starts the two playbacks of the newly closed line.
- R10: `outVsync` equals `inVsync` delayed by one clock.
- R11: Writing the next line, including a sample on the hsync cycle itself, never changes the line that is being played back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the input pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample strobe |
| inHsync | input | 1 | One-clock pulse at the start of an input line |
| inVsync | input | 1 | Input vertical sync, passed through |
| inLuma | input | PIX_W | Luma sample |
| inCb | input | PIX_W | Blue colour-difference sample |
| inCr | input | PIX_W | Red colour-difference sample |
| syncWidth | input | SW_W | Output hsync width in clocks |
| outValid | output | 1 | Active-picture qualifier at the doubled rate |
| outHsync | output | 1 | Regenerated horizontal sync, one per playback |
| outVsync | output | 1 | Vertical sync delayed by one clock |
| outLuma | output | PIX_W | Luma at the doubled rate |
| outCb | output | PIX_W | Blue colour-difference at the doubled rate |
| outCr | output | PIX_W | Red colour-difference at the doubled rate |

## Verification
Most internal faults show up within one readout cycle. A wrong bank select or fill count shows up at the first active cycle of the next playback, as stale pixels or as black appearing in the wrong place. A sequencer that counts wrongly moves the sync and valid windows, and the move is visible in the second playback or in the idle gap after it. A chroma address error shows on the odd-numbered pixel positions, which must repeat the chroma of the even position before them. The reference model predicts every output on every clock, including idle and reset cycles, so a mismatch is reported in the same cycle it first appears.

// File: rtl/scanDoublerPkg.sv
package scanDoublerPkg;

  // Strobes handed from the control section to the datapath each clock.
  typedef struct packed {
    logic wrEn;      // store the current sample into the luma memory
    logic wrChroma;  // store the current chroma pair (even position)
    logic rdActive;  // this readout cycle lies in the active window
    logic rdBlack;   // this readout position lies past the captured samples
    logic rdSync;    // this readout cycle lies in the hsync pulse
  } dblStrobes_t;

  function automatic int unsigned halfMid(input int unsigned width);
    return 32'd1 << (width - 1);
  endfunction

endpackage

// File: rtl/scanDoublerRam.sv
module scanDoublerRam #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);

  logic [W-1:0] mem [DEPTH];

  // Registered read; a write to the same address returns the old word.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end

endmodule

// File: rtl/scanDoublerCtrl.sv
module scanDoublerCtrl
  import scanDoublerPkg::*;
#(
  parameter int LINE_LEN    = 512,
  parameter int HALF_PERIOD = 640,
  parameter int ACT_START   = 96,
  parameter int SW_W        = 8,
  localparam int AW         = $clog2(LINE_LEN),
  localparam int CW         = $clog2(HALF_PERIOD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic            inHsync,
  input  logic [SW_W-1:0] syncWidth,
  output dblStrobes_t     stb,
  output logic [AW:0]     wrAddr,
  output logic [AW:0]     rdAddr
);

  localparam logic [AW:0]   LEN_V   = (AW+1)'(LINE_LEN);
  localparam logic [CW-1:0] CNT_END = CW'(HALF_PERIOD - 1);
  localparam logic [CW:0]   WIN_LO  = (CW+1)'(ACT_START);
  localparam logic [CW:0]   WIN_HI  = (CW+1)'(ACT_START + LINE_LEN);

  // write side
  logic          wrBank;
  logic          wrOpen;
  logic [AW:0]   wrCount;
  logic [AW:0]   wrIdx;
  logic          wrBankSel;

  // read side
  logic          rdBank;
  logic [AW:0]   readFill;
  logic          running;
  logic          second;
  logic [CW-1:0] cnt;
  logic [AW-1:0] pixIdx;
  logic          inWin;

  always_comb begin
    wrIdx        = inHsync ? '0 : wrCount;
    wrBankSel    = inHsync ? ~wrBank : wrBank;
    stb.wrEn     = inValid && (inHsync || (wrOpen && (wrCount < LEN_V)));
    stb.wrChroma = stb.wrEn && !wrIdx[0];
  end

  assign wrAddr = {wrBankSel, wrIdx[AW-1:0]};

  always_comb begin
    inWin        = running && ({1'b0, cnt} >= WIN_LO) && ({1'b0, cnt} < WIN_HI);
    pixIdx       = AW'(32'(cnt) - ACT_START);
    stb.rdActive = inWin;
    stb.rdBlack  = {1'b0, pixIdx} >= readFill;
    stb.rdSync   = running && (32'(cnt) < 32'(syncWidth));
  end

  assign rdAddr = {rdBank, pixIdx};

  // capture bookkeeping and bank swap
  always_ff @(posedge clk) begin
    if (rst) begin
      wrBank   <= 1'b0;
      rdBank   <= 1'b1;
      wrOpen   <= 1'b0;
      wrCount  <= '0;
      readFill <= '0;
    end else if (inHsync) begin
      wrBank   <= ~wrBank;
      rdBank   <= wrBank;
      wrOpen   <= 1'b1;
      readFill <= wrCount;
      wrCount  <= inValid ? (AW+1)'(1) : '0;
    end else if (stb.wrEn) begin
      wrCount  <= wrCount + 1'b1;
    end
  end

  // readout sequencer: two playbacks of HALF_PERIOD clocks each
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      second  <= 1'b0;
      cnt     <= '0;
    end else if (inHsync) begin
      running <= 1'b1;
      second  <= 1'b0;
      cnt     <= '0;
    end else if (running) begin
      if (cnt == CNT_END) begin
        cnt    <= '0;
        second <= 1'b1;
        if (second) running <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: the capture count never passes the line length
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (wrCount <= LEN_V) && (readFill <= LEN_V));

  // R9: every hsync restarts the first playback
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    inHsync |=> (running && (cnt == '0) && !second));

  // R8: the sequencer stops after the second playback
  p_two_reads_r8: assert property (@(posedge clk) disable iff (rst)
    (running && second && (cnt == CNT_END) && !inHsync) |=> !running);

  // R11: outside the swap cycle, writes never target the bank being read
  p_bank_split_r11: assert property (@(posedge clk) disable iff (rst)
    (stb.wrEn && !inHsync) |-> (wrAddr[AW] != rdAddr[AW]));

endmodule

// File: rtl/scanDoublerPath.sv
module scanDoublerPath
  import scanDoublerPkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 512,
  localparam int AW      = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  dblStrobes_t      stb,
  input  logic [AW:0]      wrAddr,
  input  logic [AW:0]      rdAddr,
  input  logic             inVsync,
  input  logic [PIX_W-1:0] inLuma,
  input  logic [PIX_W-1:0] inCb,
  input  logic [PIX_W-1:0] inCr,
  output logic             outValid,
  output logic             outHsync,
  output logic             outVsync,
  output logic [PIX_W-1:0] outLuma,
  output logic [PIX_W-1:0] outCb,
  output logic [PIX_W-1:0] outCr
);

  localparam logic [PIX_W-1:0] MID = PIX_W'(halfMid(PIX_W));
  localparam int NCOMP = 3;

  logic [NCOMP-1:0][PIX_W-1:0] wrData;
  logic [NCOMP-1:0][PIX_W-1:0] rdData;

  assign wrData = {inCr, inCb, inLuma};

  // component 0 is luma at full depth; 1 and 2 are chroma at half depth
  for (genvar g = 0; g < NCOMP; g++) begin : g_comp
    localparam bit IS_LUMA = (g == 0);
    localparam int RAW     = IS_LUMA ? AW + 1 : AW;
    logic [RAW-1:0] wa;
    logic [RAW-1:0] ra;
    logic           we;
    if (IS_LUMA) begin : g_full
      assign wa = wrAddr;
      assign ra = rdAddr;
      assign we = stb.wrEn;
    end else begin : g_half
      assign wa = {wrAddr[AW], wrAddr[AW-1:1]};
      assign ra = {rdAddr[AW], rdAddr[AW-1:1]};
      assign we = stb.wrChroma;
    end
    scanDoublerRam #(.W(PIX_W), .DEPTH(1 << RAW)) i_ram (
      .clk (clk),
      .we  (we),
      .wa  (wa),
      .wd  (wrData[g]),
      .ra  (ra),
      .rd  (rdData[g])
    );
  end

  logic validQ, syncQ, blackQ, vsyncQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
      syncQ  <= 1'b0;
      blackQ <= 1'b1;
      vsyncQ <= 1'b0;
    end else begin
      validQ <= stb.rdActive;
      syncQ  <= stb.rdSync;
      blackQ <= stb.rdBlack;
      vsyncQ <= inVsync;
    end
  end

  logic showPix;
  assign showPix  = validQ && !blackQ;
  assign outValid = validQ;
  assign outHsync = syncQ;
  assign outVsync = vsyncQ;
  assign outLuma  = showPix ? rdData[0] : '0;
  assign outCb    = showPix ? rdData[1] : MID;
  assign outCr    = showPix ? rdData[2] : MID;

  // R7: a position past the captured samples comes out black but valid
  p_tail_black_r7: assert property (@(posedge clk) disable iff (rst)
    (stb.rdActive && stb.rdBlack) |=> (outValid && (outLuma == '0) && (outCb == MID)));

  // R8: no active window from the control means no valid output next cycle
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !stb.rdActive |=> !outValid);

  // R10: vertical sync is a one-clock delay of the input
  p_vsync_pass_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (outVsync == $past(inVsync)));

endmodule

// File: rtl/scanDoubler.sv
module scanDoubler
  import scanDoublerPkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int LINE_LEN    = 512,
  parameter int HALF_PERIOD = 640,
  parameter int ACT_START   = 96,
  parameter int SW_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inHsync,
  input  logic             inVsync,
  input  logic [PIX_W-1:0] inLuma,
  input  logic [PIX_W-1:0] inCb,
  input  logic [PIX_W-1:0] inCr,
  input  logic [SW_W-1:0]  syncWidth,
  output logic             outValid,
  output logic             outHsync,
  output logic             outVsync,
  output logic [PIX_W-1:0] outLuma,
  output logic [PIX_W-1:0] outCb,
  output logic [PIX_W-1:0] outCr
);

  localparam int AW = $clog2(LINE_LEN);

  dblStrobes_t stb;
  logic [AW:0] wrAddr;
  logic [AW:0] rdAddr;

  scanDoublerCtrl #(
    .LINE_LEN    (LINE_LEN),
    .HALF_PERIOD (HALF_PERIOD),
    .ACT_START   (ACT_START),
    .SW_W        (SW_W)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inHsync   (inHsync),
    .syncWidth (syncWidth),
    .stb       (stb),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr)
  );

  scanDoublerPath #(
    .PIX_W    (PIX_W),
    .LINE_LEN (LINE_LEN)
  ) i_path (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .inVsync  (inVsync),
    .inLuma   (inLuma),
    .inCb     (inCb),
    .inCr     (inCr),
    .outValid (outValid),
    .outHsync (outHsync),
    .outVsync (outVsync),
    .outLuma  (outLuma),
    .outCb    (outCb),
    .outCr    (outCr)
  );

endmodule

// File: tb/test_scanDoubler.sv
module test_scanDoubler;

  localparam int PIX_W = 8;
  localparam int LEN   = 16;
  localparam int HALF  = 28;
  localparam int ACT   = 6;
  localparam int SW_W  = 8;
  localparam int MID   = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inHsync = 1'b0, inVsync = 1'b0;
  logic [PIX_W-1:0] inLuma = '0, inCb = '0, inCr = '0;
  logic [SW_W-1:0] syncWidth = 8'd3;
  logic outValid, outHsync, outVsync;
  logic [PIX_W-1:0] outLuma, outCb, outCr;

  always #5 clk = ~clk;

  scanDoubler #(
    .PIX_W(PIX_W), .LINE_LEN(LEN), .HALF_PERIOD(HALF), .ACT_START(ACT), .SW_W(SW_W)
  ) i_scanDoubler (
    .clk(clk), .rst(rst), .inValid(inValid), .inHsync(inHsync), .inVsync(inVsync),
    .inLuma(inLuma), .inCb(inCb), .inCr(inCr), .syncWidth(syncWidth),
    .outValid(outValid), .outHsync(outHsync), .outVsync(outVsync),
    .outLuma(outLuma), .outCb(outCb), .outCr(outCr)
  );

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit finished = 0;
  string phase = "R1 reset";

  // behavioural reference: queues of captured and shown samples
  logic [7:0] curY[$], curCb[$], curCr[$];
  logic [7:0] shownY[$], shownCb[$], shownCr[$];
  bit open = 0;
  int pos = -1;
  int c, k;
  int expValid = 0, expHs = 0, expVs = 0, expY = 0, expCb = MID, expCr = MID;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      pos = -1; open = 0;
      curY.delete(); curCb.delete(); curCr.delete();
      shownY.delete(); shownCb.delete(); shownCr.delete();
      expValid = 0; expHs = 0; expVs = 0; expY = 0; expCb = MID; expCr = MID;
    end else begin
      expVs = int'(inVsync);
      expValid = 0; expHs = 0; expY = 0; expCb = MID; expCr = MID;
      if (pos >= 0) begin
        c = pos % HALF;
        expHs = (c < int'(syncWidth)) ? 1 : 0;
        if (c >= ACT && c < ACT + LEN) begin
          expValid = 1;
          k = c - ACT;
          if (k < shownY.size()) begin
            expY = shownY[k]; expCb = shownCb[k/2]; expCr = shownCr[k/2];
          end
        end
      end
      if (inHsync) begin
        shownY = curY; shownCb = curCb; shownCr = curCr;
        curY.delete(); curCb.delete(); curCr.delete();
        open = 1; pos = 0;
      end else if (pos >= 0) begin
        pos++;
        if (pos == 2 * HALF) pos = -1;
      end
      if (open && inValid && curY.size() < LEN) begin
        if (curY.size() % 2 == 0) begin
          curCb.push_back(inCb); curCr.push_back(inCr);
        end
        curY.push_back(inLuma);
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", what, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(int'(outValid) == expValid, "R5 outValid", int'(outValid), expValid);
      chk(int'(outHsync) == expHs, "R4 outHsync", int'(outHsync), expHs);
      chk(int'(outVsync) == expVs, "R10 outVsync", int'(outVsync), expVs);
      chk(int'(outLuma) == expY, "R5 R7 outLuma", int'(outLuma), expY);
      chk(int'(outCb) == expCb, "R6 outCb", int'(outCb), expCb);
      chk(int'(outCr) == expCr, "R6 outCr", int'(outCr), expCr);
    end
  end

  task automatic sendLine(input int nSamp, input int stride, input int period, input int seed);
    for (int t = 0; t < period; t++) begin
      @(negedge clk);
      inHsync = (t == 0);
      inValid = (t % stride == 0) && (t / stride < nSamp);
      inVsync = (t < 3) && (seed % 2 == 0);
      inLuma  = 8'(seed * 17 + t + 1);
      inCb    = 8'(seed * 5 + t * 3 + 2);
      inCr    = 8'(250 - t - seed * 9);
    end
  endtask

  task automatic finishRun();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state held at the ports
    chk(outValid == 1'b0 && outHsync == 1'b0 && outVsync == 1'b0, "R1 idle controls",
        int'({outValid, outHsync, outVsync}), 0);
    chk(outLuma == 8'd0 && outCb == 8'(MID) && outCr == 8'(MID), "R1 black data",
        int'(outLuma), 0);
    @(negedge clk); rst = 1'b0;
    // R2: samples before the first hsync are discarded
    phase = "R2 pre-hsync samples";
    for (int t = 0; t < 10; t++) begin
      @(negedge clk); inValid = 1'b1; inLuma = 8'(99 + t); inVsync = (t == 4);
    end
    // R3: first line plays back empty (black), then a real line twice
    phase = "R3 full lines";
    sendLine(LEN, 2, 2 * HALF, 1);
    sendLine(LEN, 2, 2 * HALF, 2);
    // R7: short line leaves a black tail; R4 with zero width
    phase = "R7 short line, R4 no pulse";
    syncWidth = 8'd0;
    sendLine(10, 2, 2 * HALF, 3);
    // R2: samples past LINE_LEN are discarded
    phase = "R2 overlong line";
    syncWidth = 8'd5;
    sendLine(LEN + 4, 2, 2 * HALF, 4);
    // R9: early hsync cuts a playback; R4 wide pulse; R11 write on swap cycle
    phase = "R9 early hsync, R11 ping-pong";
    syncWidth = 8'd40;
    sendLine(LEN, 1, 30, 5);
    sendLine(LEN, 1, 19, 6);
    // R8: long gap, outputs idle after both playbacks
    phase = "R8 idle gap";
    syncWidth = 8'd4;
    sendLine(LEN, 2, 90, 7);
    phase = "R6 odd positions";
    sendLine(11, 2, 2 * HALF, 8);
    sendLine(LEN, 2, 2 * HALF + 20, 9);
    @(negedge clk); inValid = 1'b0; inHsync = 1'b0;
    repeat (5) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      finishRun();
    end
  end

endmodule